// File: doc/BRIEF.md
# SPI Slave Engine with Sticky Error Events

This block is an SPI target that runs entirely on the system clock. The serial clock, the data input and the active-low select line each pass through a two-flop synchronizer. The block then finds serial clock edges by comparing the synchronized level against its previous value. Words are 8 bits wide and travel MSB first. Outgoing words come from a 16-entry transmit FIFO and incoming words go to a 16-entry receive FIFO. The system clock must run more than four times faster than the serial clock.

The host uses a small register port with a 2-bit address:

- 0: control.
- 1: status. Reads return sticky events and FIFO levels; writes clear status bits.
- 2: transmit push.
- 3: receive pop.

Six sticky events are recorded:

- selection while disabled,
- each select assertion,
- the transmit FIFO running dry after its last stored word,
- the receive FIFO leaving empty,
- a word started with nothing to send,
- a word lost to a full receive FIFO.

One interrupt line is the OR of the set bits, gated by a global enable.

Top module: `spi_slave_irq`

## Requirements
- R1: After reset the status bits are 0, the control register is 0, `irq_o` and `miso_oe_o` are low, and a status read shows bit 9 (receive FIFO empty) = 1 and bit 8 (transmit FIFO full) = 0.
- R2: Control bit 0 enables the slave, bit 1 is the clock idle level (CPOL) and bit 2 is the phase (CPHA). In all four modes, each 8-bit word shifts MSB first. Transmit words leave in push order and received words are read from address 3 in arrival order.
- R3: `miso_oe_o` is high only while select is low and the slave is enabled. With CPHA=0 the first bit is on `miso_o` before the first clock edge.
- R4: When select falls while control bit 0 is 0, status bit 0 is set. No data is received and the transmit FIFO is not consumed.
- R5: Every falling edge of select sets status bit 1.
- R6: When the first bit of a word is sampled and the transmit FIFO had no word at load time, status bit 4 is set and the word shifts out as all zeros.
- R7: When a word completes while the receive FIFO holds 16 words, that word is dropped, status bit 5 is set, and the stored words are unchanged.
- R8: Status bit 2 is set when a word taken from the transmit FIFO completes and the FIFO is then empty.
- R9: Status bit 3 is set when a received word is written into an empty receive FIFO.
- R10: Status bits 5:0 are sticky. Writing address 1 clears exactly the bits written as 1.
- R11: `irq_o` is high exactly when control bit 3 is 1 and some status bit is set.
- R12: When select rises mid-word, the partial received bits are discarded and the next selection starts a fresh word. A transmit word whose first bit was sampled counts as consumed.
- R13: Pushes to a full transmit FIFO (16 words) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 3) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| irq_o | output | 1 | Interrupt |

## Verification
The over-run event and the transmit-empty event can both fire on the same word completion. The bench provokes this by filling the receive FIFO with 16 words and then sending one more word that is the last one stored for transmit. It then expects the status to show over-run and transmit-empty together, with receive-not-empty absent. It also expects the 16 stored words to read back untouched while the master still receives the final transmit word intact. Random data runs in all four clock modes, alongside directed under-run, disabled-selection and partial-word cases.

// File: rtl/spis_pkg.sv
package spis_pkg;

    localparam int WORD_W     = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int REG_W      = 16;
    localparam int EV_N       = 6;

    localparam int EV_MODF  = 0;
    localparam int EV_SSEL  = 1;
    localparam int EV_TXE   = 2;
    localparam int EV_RXNE  = 3;
    localparam int EV_UNDER = 4;
    localparam int EV_OVER  = 5;

    localparam int ST_TXFULL  = 8;
    localparam int ST_RXEMPTY = 9;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_TXD  = 2'd2,
        A_RXD  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic irq_en;
        logic cpha;
        logic cpol;
        logic en;
    } ctrl_t;

    function automatic logic lead_edge(input logic cpol, input logic rise, input logic fall);
        return cpol ? fall : rise;
    endfunction

    function automatic logic trail_edge(input logic cpol, input logic rise, input logic fall);
        return cpol ? rise : fall;
    endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int          N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/spis_status.sv
module spis_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         irq_en,
    output logic [N-1:0] status_o,
    output logic         irq_o
);
    always_ff @(posedge clk) begin
        if (rst) status_o <= '0;
        else     status_o <= (status_o & ~clr_i) | set_i;
    end

    assign irq_o = irq_en & (|status_o);
endmodule

// File: rtl/spis_engine.sv
module spis_engine
    import spis_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic         sck_s,
    input  logic         mosi_s,
    input  logic         sel_s,
    input  logic [W-1:0] tx_head,
    input  logic         tx_empty,
    output logic         tx_pop,
    input  logic         rx_full,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         miso,
    output logic         miso_oe,
    output logic         ev_modf,
    output logic         ev_ssel,
    output logic         ev_under,
    output logic         ev_over,
    output logic         ev_txe,
    output logic         word_last
);
    localparam int CW = $clog2(W);

    logic          sck_q, sel_q, act_q;
    logic          act, start, rise, fall, lead, trail, smp, drv;
    logic          first_smp;
    logic [W-1:0]  tx_sr;
    logic [W-2:0]  rx_sr;
    logic [CW-1:0] cnt;
    logic          from_fifo;
    logic [W-1:0]  load_val;

    assign act   = sel_s & ctrl.en;
    assign start = act & ~act_q;
    assign rise  = sck_s & ~sck_q;
    assign fall  = ~sck_s & sck_q;
    assign lead  = lead_edge(ctrl.cpol, rise, fall);
    assign trail = trail_edge(ctrl.cpol, rise, fall);
    assign smp   = act & act_q & (ctrl.cpha ? trail : lead);
    assign drv   = act & act_q & (ctrl.cpha ? lead : trail);

    assign load_val  = tx_empty ? '0 : tx_head;
    assign first_smp = smp & (cnt == '0);
    assign word_last = smp & (cnt == CW'(W-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            sel_q     <= 1'b0;
            act_q     <= 1'b0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            cnt       <= '0;
            from_fifo <= 1'b0;
        end else begin
            sck_q <= sck_s;
            sel_q <= sel_s;
            act_q <= act;
            if (!act) begin
                cnt       <= '0;
                tx_sr     <= '0;
                from_fifo <= 1'b0;
            end else if (start) begin
                cnt <= '0;
                if (!ctrl.cpha) begin
                    tx_sr     <= load_val;
                    from_fifo <= ~tx_empty;
                end else begin
                    tx_sr     <= '0;
                    from_fifo <= 1'b0;
                end
            end else begin
                if (drv) begin
                    if (cnt == '0) begin
                        tx_sr     <= load_val;
                        from_fifo <= ~tx_empty;
                    end else begin
                        tx_sr <= {tx_sr[W-2:0], 1'b0};
                    end
                end
                if (smp) begin
                    rx_sr <= {rx_sr[W-3:0], mosi_s};
                    cnt   <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
                end
            end
        end
    end

    assign rx_word  = {rx_sr, mosi_s};
    assign tx_pop   = first_smp & from_fifo;
    assign ev_under = first_smp & ~from_fifo;
    assign rx_push  = word_last & ~rx_full;
    assign ev_over  = word_last & rx_full;
    assign ev_txe   = word_last & from_fifo & tx_empty;
    assign ev_ssel  = sel_s & ~sel_q;
    assign ev_modf  = sel_s & ~sel_q & ~ctrl.en;
    assign miso     = tx_sr[W-1];
    assign miso_oe  = act;
endmodule

// File: rtl/spi_slave_irq.sv
module spi_slave_irq
    import spis_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sck_i,
    input  logic             mosi_i,
    input  logic             ss_n_i,
    output logic             miso_o,
    output logic             miso_oe_o,
    output logic             irq_o
);
    localparam int W = WORD_W;

    ctrl_t           ctrl;
    logic [2:0]      sync_q;
    logic            sck_s, mosi_s, sel_s;
    logic [W-1:0]    tx_head, rx_head, rx_word;
    logic            tx_push, tx_pop, tx_full, tx_empty;
    logic            rx_push, rx_pop, rx_full, rx_empty;
    logic            word_last;
    logic            e_modf, e_ssel, e_under, e_over, e_txe;
    logic [EV_N-1:0] ev, st_clr, status;
    logic            unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:W];

    spis_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst),
        .d({ss_n_i, sck_i, mosi_i}),
        .q(sync_q)
    );
    assign sel_s  = ~sync_q[2];
    assign sck_s  = sync_q[1];
    assign mosi_s = sync_q[0];

    always_ff @(posedge clk) begin
        if (rst)                                   ctrl <= '0;
        else if (reg_wr && reg_addr == 2'(A_CTRL)) ctrl <= ctrl_t'(reg_wdata[3:0]);
    end

    assign tx_push = reg_wr & (reg_addr == 2'(A_TXD));
    assign rx_pop  = reg_rd & (reg_addr == 2'(A_RXD));
    assign st_clr  = (reg_wr && reg_addr == 2'(A_STAT)) ? reg_wdata[EV_N-1:0] : '0;

    spis_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst(rst), .push(tx_push), .din(reg_wdata[W-1:0]),
        .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spis_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spis_engine #(.W(W)) u_eng (
        .clk(clk), .rst(rst), .ctrl(ctrl),
        .sck_s(sck_s), .mosi_s(mosi_s), .sel_s(sel_s),
        .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .miso(miso_o), .miso_oe(miso_oe_o),
        .ev_modf(e_modf), .ev_ssel(e_ssel), .ev_under(e_under),
        .ev_over(e_over), .ev_txe(e_txe), .word_last(word_last)
    );

    always_comb begin
        ev           = '0;
        ev[EV_MODF]  = e_modf;
        ev[EV_SSEL]  = e_ssel;
        ev[EV_TXE]   = e_txe;
        ev[EV_RXNE]  = rx_push & rx_empty;
        ev[EV_UNDER] = e_under;
        ev[EV_OVER]  = e_over;
    end

    spis_status #(.N(EV_N)) u_stat (
        .clk(clk), .rst(rst), .set_i(ev), .clr_i(st_clr),
        .irq_en(ctrl.irq_en), .status_o(status), .irq_o(irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            2'(A_CTRL): reg_rdata[3:0] = ctrl;
            2'(A_STAT): begin
                reg_rdata[EV_N-1:0]  = status;
                reg_rdata[ST_TXFULL]  = tx_full;
                reg_rdata[ST_RXEMPTY] = rx_empty;
            end
            2'(A_RXD):  reg_rdata[W-1:0] = rx_head;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spis_checks.sv
module spis_checks
    import spis_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            en,
    input logic            irq_en,
    input logic            sel,
    input logic            miso_oe,
    input logic            irq,
    input logic [EV_N-1:0] status,
    input logic [EV_N-1:0] clr,
    input logic [EV_N-1:0] ev,
    input logic            word_last,
    input logic            rx_full,
    input logic            rx_pop
);
    assert_oe_select_R3: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> (sel && en));

    assert_modf_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(sel) && !en) |=> status[EV_MODF]);

    assert_ssel_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sel) |=> status[EV_SSEL]);

    assert_under_R6: assert property (@(posedge clk) disable iff (rst)
        ev[EV_UNDER] |=> status[EV_UNDER]);

    assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (word_last && rx_full && !rx_pop) |=> (rx_full && status[EV_OVER]));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        (clr != '0 && ev == '0) |=> ((status & $past(clr)) == '0));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((status & $past(status)) == $past(status)));

    assert_irq_on_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_en && status != '0) |-> irq);

    assert_irq_off_R11: assert property (@(posedge clk) disable iff (rst)
        (!irq_en || status == '0) |-> !irq);
endmodule

bind spi_slave_irq spis_checks u_chk (
    .clk(clk), .rst(rst), .en(ctrl.en), .irq_en(ctrl.irq_en),
    .sel(sel_s), .miso_oe(miso_oe_o), .irq(irq_o),
    .status(status), .clr(st_clr), .ev(ev),
    .word_last(word_last), .rx_full(rx_full), .rx_pop(rx_pop)
);

// File: tb/spi_slave_irq_test.sv
module spi_slave_irq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic        miso_o, miso_oe_o, irq_o;

    int checks = 0;
    int errors = 0;
    logic m_cpol = 1'b0, m_cpha = 1'b0;

    localparam logic [5:0] B_MODF = 6'h01, B_SSEL = 6'h02, B_TXE = 6'h04,
                           B_RXNE = 6'h08, B_UNDER = 6'h10, B_OVER = 6'h20;

    always #4 clk = ~clk;

    spi_slave_irq uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_i(sck), .mosi_i(mosi),
        .ss_n_i(ss_n), .miso_o(miso_o), .miso_oe_o(miso_oe_o), .irq_o(irq_o)
    );

    function automatic logic [3:0] ctrl_word(input logic ie, input logic cpha,
                                             input logic cpol, input logic en);
        return {ie, cpha, cpol, en};
    endfunction

    function automatic logic exp_irq(input logic ie, input logic [5:0] st);
        return ie && (st != 6'h0);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic set_mode(input logic ie, input logic cpha, input logic cpol, input logic en);
        m_cpol = cpol; m_cpha = cpha;
        reg_write(2'd0, {12'h0, ctrl_word(ie, cpha, cpol, en)});
        sck = cpol;
        half();
    endtask

    task automatic select();
        ss_n = 1'b0;
        half();
    endtask

    task automatic release_ss();
        half();
        ss_n = 1'b1;
        half();
    endtask

    task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
        mi = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (!m_cpha) begin
                mosi = mo[i]; half(); mi[i] = miso_o; sck = ~m_cpol;
                half(); sck = m_cpol;
            end else begin
                half(); sck = ~m_cpol; mosi = mo[i];
                half(); mi[i] = miso_o; sck = m_cpol;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [7:0]  mi;
        logic [7:0]  txw [17];
        logic [7:0]  rxw [17];
        void'($urandom(32'd4242));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd1, rd);
        chk("R1 status", rd, 16'h0200);
        reg_read(2'd0, rd);
        chk("R1 ctrl", rd, 16'h0);
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 oe", miso_oe_o, 1'b0);

        // R2/R3/R5/R8/R9/R10: random data, all four modes
        for (int m = 0; m < 4; m++) begin
            set_mode(1'b0, m[1], m[0], 1'b1);
            for (int k = 0; k < 3; k++) begin
                txw[k] = 8'($urandom_range(255));
                rxw[k] = 8'($urandom_range(255));
                reg_write(2'd2, {8'h0, txw[k]});
            end
            select();
            chk("R3 oe while selected", miso_oe_o, 1'b1);
            if (!m_cpha) chk("R3 first bit before edge", miso_o, txw[0][7]);
            for (int k = 0; k < 3; k++) begin
                xfer(rxw[k], 8, mi);
                chk("R2 miso word", mi, txw[k]);
            end
            release_ss();
            chk("R3 oe after release", miso_oe_o, 1'b0);
            reg_read(2'd1, rd);
            chk("R5 R8 R9 status", rd[5:0], B_SSEL | B_TXE | B_RXNE);
            for (int k = 0; k < 3; k++) begin
                reg_read(2'd3, rd);
                chk("R2 mosi word", rd[7:0], rxw[k]);
            end
            reg_write(2'd1, 16'h003F);
            reg_read(2'd1, rd);
            chk("R10 cleared", rd, 16'h0200);
        end

        // R6 under-run
        set_mode(1'b0, 1'b0, 1'b0, 1'b1);
        select();
        xfer(8'hA5, 8, mi);
        release_ss();
        chk("R6 zeros", mi, 8'h00);
        reg_read(2'd1, rd);
        chk("R6 status", rd[5:0], B_SSEL | B_UNDER | B_RXNE);
        reg_read(2'd3, rd);
        chk("R6 rx word", rd[7:0], 8'hA5);
        reg_write(2'd1, 16'h003F);

        // R4 mode fault: selected while disabled
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        reg_write(2'd2, 16'h003C);
        select();
        chk("R4 oe stays low", miso_oe_o, 1'b0);
        xfer(8'h77, 8, mi);
        release_ss();
        reg_read(2'd1, rd);
        chk("R4 status", rd[5:0], B_MODF | B_SSEL);
        chk("R4 rx empty", rd[9], 1'b1);
        reg_write(2'd1, 16'h003F);
        set_mode(1'b0, 1'b0, 1'b0, 1'b1);
        select();
        xfer(8'h11, 8, mi);
        release_ss();
        chk("R4 tx not consumed", mi, 8'h3C);
        reg_read(2'd3, rd);
        reg_write(2'd1, 16'h003F);

        // R13/R7/R8: fill both sides, then over-run with tx-empty
        set_mode(1'b0, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 17; k++) begin
            txw[k] = 8'($urandom_range(255));
            rxw[k] = 8'($urandom_range(255));
            reg_write(2'd2, {8'h0, txw[k]});
        end
        reg_read(2'd1, rd);
        chk("R13 tx full", rd[8], 1'b1);
        select();
        for (int k = 0; k < 16; k++) begin
            xfer(rxw[k], 8, mi);
            chk("R13 order kept", mi, txw[k]);
        end
        release_ss();
        reg_read(2'd1, rd);
        chk("R8 status after 16", rd[5:0], B_SSEL | B_TXE | B_RXNE);
        chk("R13 tx not full", rd[8], 1'b0);
        reg_write(2'd1, 16'h003F);
        reg_write(2'd2, {8'h0, txw[16]});
        select();
        xfer(rxw[16], 8, mi);
        release_ss();
        chk("R7 last tx intact", mi, txw[16]);
        reg_read(2'd1, rd);
        chk("R7 R8 same word", rd[5:0], B_SSEL | B_TXE | B_OVER);
        for (int k = 0; k < 16; k++) begin
            reg_read(2'd3, rd);
            chk("R7 stored words", rd[7:0], rxw[k]);
        end
        reg_read(2'd1, rd);
        chk("R7 dropped word", rd[9], 1'b1);
        reg_write(2'd1, 16'h003F);

        // R12 partial word
        set_mode(1'b0, 1'b0, 1'b0, 1'b1);
        reg_write(2'd2, 16'h00C3);
        reg_write(2'd2, 16'h005A);
        select();
        xfer(8'hFF, 3, mi);
        release_ss();
        select();
        xfer(8'h96, 8, mi);
        release_ss();
        chk("R12 next tx word", mi, 8'h5A);
        reg_read(2'd3, rd);
        chk("R12 fresh rx word", rd[7:0], 8'h96);
        reg_read(2'd1, rd);
        chk("R12 partial dropped", rd[9], 1'b1);
        chk("R12 status", rd[5:0], B_SSEL | B_TXE | B_RXNE);

        // R11 interrupt gating, R10 selective clear
        chk("R11 irq gated", irq_o, exp_irq(1'b0, rd[5:0]));
        set_mode(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R11 irq on", irq_o, exp_irq(1'b1, B_SSEL | B_TXE | B_RXNE));
        reg_write(2'd1, {10'h0, B_SSEL});
        reg_read(2'd1, rd);
        chk("R10 one bit cleared", rd[5:0], B_TXE | B_RXNE);
        chk("R11 irq still on", irq_o, 1'b1);
        reg_write(2'd1, {10'h0, B_TXE | B_RXNE});
        reg_read(2'd1, rd);
        chk("R10 all cleared", rd[5:0], 6'h0);
        chk("R11 irq off", irq_o, exp_irq(1'b1, 6'h0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule